// File: doc/BRIEF.md
# Bidirectional Wired-OR Bus Repeater Channel

This block joins two segments, A and B, of an active-low, wired-OR parallel bus, one channel per data or parity line. Each line is sampled as a plain bit on both sides. A level of 0 means the line is asserted. For every line the block works out which segment is the source. It latches the incoming assertion and waits for the transfer strobe before it passes the assertion to the other segment. The block then drives that segment through a pull-down enable and a separate pull-up enable. When the pull-up enable is 0, the pull-up is tri-stated.

When forwarding starts, the forwarded level is held for a fixed number of cycles, so bounce on the source line is ignored. A registered output stage gives the load segment a steady window. When the source releases the line, the load side is actively pulled up for a fixed recovery interval. During that interval the line's direction is locked and no new assertion from either side is accepted. The block's own drive on the load segment therefore can never come back as an incoming signal.

The parameters are `WIDTH` (number of lines), `HOLD_CYC` (hold-filter length, at least 1) and `REC_CYC` (recovery length, at least 2). The block works on a single clock. Bus inputs are taken as already sampled in that clock domain, and `rst_n` is taken as released synchronously to `clk`.

Top module: `bus_rptr_chan`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all four pull enable outputs are 0 on every line.
- R2: An idle line seen asserted (0) on side A is latched at the next clock edge. B's pull-down enable for that line stays 0 until `xfer_stb` is sampled high on a later edge. It rises in the cycle after that edge.
- R3: A line first asserted on side B is forwarded in the same way, with A's pull-down enable rising one cycle after the strobe edge.
- R4: While a line is forwarded from A to B, the block's own low level on B never makes it pull down or pull up side A. This holds through the whole recovery interval. The same rule applies mirrored for B to A.
- R5: Once forwarding starts, the load-side pull-down enable stays 1 for at least `HOLD_CYC` cycles. A release of the source line inside that window has no effect on the output.
- R6: After the hold window, a release of the source line sampled at an edge clears the load-side pull-down enable in the following cycle.
- R7: When the pull-down enable falls, the load-side pull-up enable is 1 for exactly `REC_CYC` cycles. An assertion on either side during that time is not accepted; it is latched at the first edge after the recovery interval ends.
- R8: A side never has its pull-down and pull-up enable at 1 at once. An idle line has all four enables at 0, with the pull-up tri-stated.
- R9: If both sides of an idle line assert on the same edge, side A becomes the source: B is pulled down and A is left undriven.
- R10: Each line works on its own. Lines forwarded in opposite directions at the same time do not disturb each other or the idle lines.
- R11: An assertion latched while waiting for the strobe is kept even if the source releases the line before the strobe. It is forwarded for `HOLD_CYC`+1 cycles and then enters recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously |
| a_in | input | WIDTH | Sampled levels of segment A lines, 0 = asserted |
| b_in | input | WIDTH | Sampled levels of segment B lines, 0 = asserted |
| xfer_stb | input | 1 | Transfer strobe that releases latched assertions to the load side |
| a_pd_en | output | WIDTH | Pull-down enables for segment A |
| a_pu_en | output | WIDTH | Pull-up enables for segment A, 0 = tri-stated |
| b_pd_en | output | WIDTH | Pull-down enables for segment B |
| b_pu_en | output | WIDTH | Pull-up enables for segment B, 0 = tri-stated |

## Verification
A direction bit that flips while a line is busy shows up within one cycle as a pull-down on the source segment. Through the wired-OR model this latches both segments low, and it is caught by the echo checks on that side. A hold or recovery timer loaded with the wrong value moves the fall of the pull-down enable, or the length of the pull-up pulse, by whole cycles. The bench compares these edge by edge against the cycle counts in R5 to R7. A state machine that leaves recovery early, or skips the strobe wait, drives the load segment one or more cycles before the expected edge.

// File: rtl/rptr_pkg.sv
package rptr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_HOLD,
    ST_DRIVE,
    ST_RECOV
  } rptr_st_e;

endpackage

// File: rtl/rptr_lane.sv
module rptr_lane
  import rptr_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int REC_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_asrt,
  input  logic b_asrt,
  input  logic stb,
  output logic fwd,
  output logic recov,
  output logic src_b
);

  localparam int TMR_MAX = (HOLD_CYC > REC_CYC) ? HOLD_CYC : REC_CYC;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam logic [TW-1:0] HOLD_LD = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] REC_LD  = TW'(REC_CYC - 1);

  rptr_st_e        st_q, st_d;
  logic [TW-1:0]   tmr_q, tmr_d;
  logic            tmr_en;
  logic            src_q, src_d;
  logic            src_en;
  logic            src_asrt;

  // the active source is the side that owns the line
  assign src_asrt = src_q ? b_asrt : a_asrt;
  assign src_en   = (st_q == ST_IDLE);

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    tmr_en = 1'b0;
    src_d  = src_q;
    unique case (st_q)
      ST_IDLE: begin
        if (a_asrt) begin
          st_d  = ST_CAPT;
          src_d = 1'b0;
        end else if (b_asrt) begin
          st_d  = ST_CAPT;
          src_d = 1'b1;
        end
      end
      ST_CAPT: begin
        if (stb) begin
          st_d   = ST_HOLD;
          tmr_d  = HOLD_LD;
          tmr_en = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmr_q == '0) begin
          st_d = ST_DRIVE;
        end else begin
          tmr_d  = tmr_q - TW'(1);
          tmr_en = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (!src_asrt) begin
          st_d   = ST_RECOV;
          tmr_d  = REC_LD;
          tmr_en = 1'b1;
        end
      end
      ST_RECOV: begin
        if (tmr_q == '0) begin
          st_d = ST_IDLE;
        end else begin
          tmr_d  = tmr_q - TW'(1);
          tmr_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= 1'b0;
    else if (src_en) src_q <= src_d;
  end

  assign fwd   = (st_q == ST_HOLD) || (st_q == ST_DRIVE);
  assign recov = (st_q == ST_RECOV);
  assign src_b = src_q;

  // R4
  own_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(src_q));

  // R2
  strobe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAPT && !stb) |=> (st_q == ST_CAPT));

  // R7
  recov_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOV) |=> (st_q == ST_RECOV || st_q == ST_IDLE));

endmodule

// File: rtl/rptr_pullstage.sv
module rptr_pullstage (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd,
  input  logic recov,
  input  logic src_b,
  output logic a_pd,
  output logic a_pu,
  output logic b_pd,
  output logic b_pu
);

  logic a_pd_d, a_pu_d, b_pd_d, b_pu_d;

  // load side is the one opposite the source
  always_comb begin
    a_pd_d = fwd   &  src_b;
    b_pd_d = fwd   & ~src_b;
    a_pu_d = recov &  src_b;
    b_pu_d = recov & ~src_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_pd <= 1'b0;
      a_pu <= 1'b0;
      b_pd <= 1'b0;
      b_pu <= 1'b0;
    end else begin
      a_pd <= a_pd_d;
      a_pu <= a_pu_d;
      b_pd <= b_pd_d;
      b_pu <= b_pu_d;
    end
  end

  // R8
  pd_pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_pd && a_pu) && !(b_pd && b_pu));

  // R4
  no_backfeed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((a_pd || a_pu) && (b_pd || b_pu)));

  // R5
  hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_pd) |=> b_pd);

endmodule

// File: rtl/bus_rptr_chan.sv
module bus_rptr_chan #(
  parameter int WIDTH    = 9,
  parameter int HOLD_CYC = 4,
  parameter int REC_CYC  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             xfer_stb,
  output logic [WIDTH-1:0] a_pd_en,
  output logic [WIDTH-1:0] a_pu_en,
  output logic [WIDTH-1:0] b_pd_en,
  output logic [WIDTH-1:0] b_pu_en
);

  logic [WIDTH-1:0] fwd_w, recov_w, src_b_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_line
    rptr_lane #(
      .HOLD_CYC(HOLD_CYC),
      .REC_CYC (REC_CYC)
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .a_asrt(~a_in[i]),
      .b_asrt(~b_in[i]),
      .stb   (xfer_stb),
      .fwd   (fwd_w[i]),
      .recov (recov_w[i]),
      .src_b (src_b_w[i])
    );

    rptr_pullstage u_pull (
      .clk  (clk),
      .rst_n(rst_n),
      .fwd  (fwd_w[i]),
      .recov(recov_w[i]),
      .src_b(src_b_w[i]),
      .a_pd (a_pd_en[i]),
      .a_pu (a_pu_en[i]),
      .b_pd (b_pd_en[i]),
      .b_pu (b_pu_en[i])
    );
  end

endmodule

// File: tb/test_bus_rptr_chan.sv
`timescale 1ns/1ps
module test_bus_rptr_chan;

  localparam int W = 9;
  localparam int H = 4;
  localparam int R = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] drv_a, drv_b;
  logic         stb;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_pd_en, a_pu_en, b_pd_en, b_pu_en;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done  = 1'b0;

  always #2 clk = ~clk;

  // wired-OR segments: low when any device or the repeater pulls down
  assign a_in = ~(drv_a | a_pd_en);
  assign b_in = ~(drv_b | b_pd_en);

  bus_rptr_chan #(.WIDTH(W), .HOLD_CYC(H), .REC_CYC(R)) i_bus_rptr_chan (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .xfer_stb(stb),
    .a_pd_en(a_pd_en), .a_pu_en(a_pu_en), .b_pd_en(b_pd_en), .b_pu_en(b_pu_en)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drain();
    drv_a = '0;
    drv_b = '0;
    stb   = 1'b0;
    repeat (H + R + 6) tick();
    chk("R8 idle a_pd", int'(a_pd_en), 0);
    chk("R8 idle a_pu", int'(a_pu_en), 0);
    chk("R8 idle b_pd", int'(b_pd_en), 0);
    chk("R8 idle b_pu", int'(b_pu_en), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drv_a = '0;
    drv_b = '0;
    stb   = 1'b0;
    repeat (3) tick();
    chk("R1 a_pd in reset", int'(a_pd_en), 0);
    chk("R1 b_pu in reset", int'(b_pu_en), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 all enables", int'(a_pd_en | a_pu_en | b_pd_en | b_pu_en), 0);
  endtask

  task automatic t_forward_a();
    drv_a[0] = 1'b1;
    tick();
    for (int j = 0; j < 5; j++) begin
      tick();
      chk("R2 no strobe b_pd", int'(b_pd_en[0]), 0);
    end
    stb = 1'b1;
    tick();
    chk("R2 strobe edge b_pd", int'(b_pd_en[0]), 0);
    stb = 1'b0;
    tick();
    chk("R2 forwarded b_pd", int'(b_pd_en[0]), 1);
    for (int j = 0; j < H + 2; j++) begin
      tick();
      chk("R2 b_pd held", int'(b_pd_en[0]), 1);
      chk("R4 echo a_pd", int'(a_pd_en[0]), 0);
      chk("R8 b_pu off while pd", int'(b_pu_en[0]), 0);
    end
    drv_a[0] = 1'b0;
    tick();
    chk("R6 release edge b_pd", int'(b_pd_en[0]), 1);
    tick();
    chk("R6 b_pd falls", int'(b_pd_en[0]), 0);
    chk("R7 b_pu rises", int'(b_pu_en[0]), 1);
    for (int j = 1; j < R; j++) begin
      tick();
      chk("R7 b_pu held", int'(b_pu_en[0]), 1);
      chk("R4 echo a_pd in recovery", int'(a_pd_en[0]), 0);
      chk("R4 echo a_pu in recovery", int'(a_pu_en[0]), 0);
    end
    tick();
    chk("R7 b_pu ends", int'(b_pu_en[0]), 0);
    chk("R4 a_pd after recovery", int'(a_pd_en[0]), 0);
    drain();
  endtask

  task automatic t_bounce();
    drv_a[1] = 1'b1;
    tick();
    stb = 1'b1;
    tick();
    stb = 1'b0;
    drv_a[1] = 1'b0;
    tick();
    chk("R5 pd starts", int'(b_pd_en[1]), 1);
    drv_a[1] = 1'b1;
    tick();
    chk("R5 pd through bounce", int'(b_pd_en[1]), 1);
    drv_a[1] = 1'b0;
    tick();
    chk("R5 pd through bounce", int'(b_pd_en[1]), 1);
    drv_a[1] = 1'b1;
    for (int j = 0; j < H + 3; j++) begin
      tick();
      chk("R5 pd after bounce", int'(b_pd_en[1]), 1);
      chk("R5 no pull-up", int'(b_pu_en[1]), 0);
    end
    drain();
  endtask

  task automatic t_short();
    drv_a[2] = 1'b1;
    tick();
    drv_a[2] = 1'b0;
    tick();
    tick();
    chk("R11 waits for strobe", int'(b_pd_en[2]), 0);
    stb = 1'b1;
    tick();
    stb = 1'b0;
    for (int j = 0; j < H + 1; j++) begin
      tick();
      chk("R11 latched pd", int'(b_pd_en[2]), 1);
    end
    tick();
    chk("R11 pd ends", int'(b_pd_en[2]), 0);
    chk("R11 recovery pu", int'(b_pu_en[2]), 1);
    drain();
  endtask

  task automatic t_reverse();
    drv_b[3] = 1'b1;
    tick();
    stb = 1'b1;
    tick();
    stb = 1'b0;
    tick();
    chk("R3 a_pd forwarded", int'(a_pd_en[3]), 1);
    chk("R3 b_pd off", int'(b_pd_en[3]), 0);
    drv_b[3] = 1'b0;
    repeat (H + 2) tick();
    chk("R3 a_pu recovery", int'(a_pu_en[3]), 1);
    chk("R4 echo b_pd", int'(b_pd_en[3]), 0);
    drain();
  endtask

  task automatic t_tie();
    drv_a[4] = 1'b1;
    drv_b[4] = 1'b1;
    tick();
    stb = 1'b1;
    tick();
    stb = 1'b0;
    tick();
    chk("R9 b_pd wins", int'(b_pd_en[4]), 1);
    chk("R9 a_pd off", int'(a_pd_en[4]), 0);
    drain();
  endtask

  task automatic t_recover();
    drv_a[5] = 1'b1;
    tick();
    stb = 1'b1;
    tick();
    stb = 1'b0;
    repeat (H + 2) tick();
    drv_a[5] = 1'b0;
    tick();
    drv_b[5] = 1'b1;
    stb = 1'b1;
    for (int j = 0; j < R + 2; j++) begin
      tick();
      chk("R7 no capture in recovery", int'(a_pd_en[5]), 0);
    end
    tick();
    chk("R7 capture after recovery", int'(a_pd_en[5]), 1);
    drain();
  endtask

  task automatic t_lanes();
    drv_a[6] = 1'b1;
    drv_b[7] = 1'b1;
    tick();
    stb = 1'b1;
    tick();
    stb = 1'b0;
    tick();
    chk("R10 b_pd lanes", int'(b_pd_en), 1 << 6);
    chk("R10 a_pd lanes", int'(a_pd_en), 1 << 7);
    chk("R10 idle line 8", int'(a_pu_en[8] | b_pu_en[8]), 0);
    drain();
  endtask

  initial begin
    t_reset();
    t_forward_a();
    t_bounce();
    t_short();
    t_reverse();
    t_tie();
    t_recover();
    t_lanes();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule